// File: doc/BRIEF.md
# Fall-Through Word FIFO with Per-Stage Occupancy Markers

This block is a first-in/first-out buffer in which the storage is a chain of word stages rather than a RAM with pointers. Every stage holds one data word and one occupancy flag: 1 means the stage holds a word, 0 means it is empty. A stage looks only at the flag of the stage in front of it and tells the stage behind it whether it is occupied. A written word therefore moves one stage per clock toward the output end until it reaches the last stage or queues up behind an occupied one.

The writer uses a shift-in strobe gated by an input-ready flag. The reader uses a shift-out strobe gated by an output-ready flag, and the output data always shows the last stage. The two strobes are independent, so producer and consumer may run at unrelated rates. Both are modelled as strobes in a single clock domain.

Two instances chain into a deeper buffer with no glue. The first block's output-ready drives the second block's shift-in, and the second block's input-ready drives the first block's shift-out. To make the word wider, place instances side by side with shared strobes and AND their ready flags.

Top module: `ftf_fifo`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) empties every stage. From the following cycle in_ready is 1 and out_ready is 0, and no word stored before the reset is ever delivered.
- R2: in_ready is 1 exactly when the entry stage is empty. A shift_in sampled with in_ready high stores din as a new word.
- R3: A shift_in sampled while in_ready is low is ignored: no word is added and nothing is overwritten.
- R4: A word written into an empty buffer at clock edge e raises out_ready at edge e+DEPTH-1 and not earlier (one clock per stage).
- R5: While out_ready is 1, dout shows the oldest stored word. A shift_out sampled with out_ready high removes that word.
- R6: A shift_out sampled while out_ready is low is ignored: no word is lost and no word is emitted.
- R7: Words leave in the order they were written, with no loss and no duplication, under any mix of strobes.
- R8: The buffer holds exactly DEPTH words (default 16, WIDTH default 4). With the reader idle and the writer strobing every cycle, exactly DEPTH words are accepted before in_ready stays low.
- R9: A shift_in and a shift_out that are both accepted in the same cycle both take effect.
- R10: Two instances chained through their ready flags behave as one FIFO of 2*DEPTH words that keeps the write order.
- R11: While out_ready is 1 and shift_out is 0, out_ready stays 1 and dout stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_in | input | 1 | Write strobe |
| in_ready | output | 1 | Entry stage empty, write will be taken |
| din | input | WIDTH | Write data |
| shift_out | input | 1 | Read strobe |
| out_ready | output | 1 | Last stage holds a word |
| dout | output | WIDTH | Word held in the last stage |

## Verification
The collision that matters is an accepted shift-in and an accepted shift-out in the same cycle. At that moment the entry stage loads while the last stage empties, and interior words keep moving. The random phases with both strobe rates high produce this collision many times. The bench counts the collisions and requires at least one. Correctness is judged by a reference queue: each accepted read must return the queue's oldest word, and the word count must match the count computed from accepted strobes alone.

// File: rtl/ftf_pkg.sv
// ftf_pkg: shared defaults and the per-stage action type for the
// fall-through FIFO. Assumes nothing beyond IEEE 1800-2017.
package ftf_pkg;
    localparam int DEF_DEPTH = 16;
    localparam int DEF_WIDTH = 4;

    // What one stage does at the coming clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_TAKE = 2'd1,
        ACT_GIVE = 2'd2
    } stage_act_e;
endpackage

// File: rtl/ftf_stage.sv
// ftf_stage: one word position of the chain. It keeps an occupancy flag and a
// data word. It takes a word from upstream when upstream offers one and it is
// empty. It gives its word away when it is full and downstream accepts.
// Assumes up_full/down_accept are derived from neighbour flags of the same
// clock, so take and give can never both be true in one cycle.
module ftf_stage
    import ftf_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_full,
    input  logic [WIDTH-1:0] up_data,
    input  logic             down_accept,
    output logic             full_q,
    output logic [WIDTH-1:0] data_q
);
    stage_act_e act;

    // Choose this stage's action from its own flag and its neighbours.
    always_comb begin
        if (up_full && !full_q) begin
            act = ACT_TAKE;
        end else if (full_q && down_accept) begin
            act = ACT_GIVE;
        end else begin
            act = ACT_HOLD;
        end
    end

    // Update flag and word according to the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            case (act)
                ACT_TAKE: begin
                    full_q <= 1'b1;
                    data_q <= up_data;
                end
                ACT_GIVE: begin
                    full_q <= 1'b0;
                end
                default: begin
                    full_q <= full_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/ftf_chain.sv
// ftf_chain: DEPTH stages in a row. Stage 0 is fed by the qualified write,
// the last stage is drained by the qualified read, and every interior stage
// hands over to its successor when that one is empty. Assumes DEPTH >= 2.
module ftf_chain
    import ftf_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feed,
    input  logic [WIDTH-1:0] feed_data,
    input  logic             drain,
    output logic [DEPTH-1:0] marks,
    output logic [WIDTH-1:0] tail_data
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] up_full;
    logic [DEPTH-1:0] down_acc;
    logic [WIDTH-1:0] up_word  [DEPTH];
    logic [WIDTH-1:0] st_word  [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign up_full[k] = feed;
            assign up_word[k] = feed_data;
        end else begin : g_body
            assign up_full[k] = marks[k-1];
            assign up_word[k] = st_word[k-1];
        end

        if (k == LAST) begin : g_tail
            assign down_acc[k] = drain;
        end else begin : g_link
            assign down_acc[k] = ~marks[k+1];
        end

        ftf_stage #(.WIDTH(WIDTH)) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .up_full    (up_full[k]),
            .up_data    (up_word[k]),
            .down_accept(down_acc[k]),
            .full_q     (marks[k]),
            .data_q     (st_word[k])
        );
    end

    assign tail_data = st_word[LAST];
endmodule

// File: rtl/ftf_port_ctrl.sv
// ftf_port_ctrl: the two handshake edges. Turns the raw strobes into
// qualified feed/drain pulses and publishes the ready flags and the output
// word. Assumes the head and tail flags come straight from the chain.
module ftf_port_ctrl #(
    parameter int WIDTH = 4
) (
    input  logic             shift_in,
    input  logic             shift_out,
    input  logic             head_full,
    input  logic             tail_full,
    input  logic [WIDTH-1:0] tail_data,
    output logic             in_ready,
    output logic             out_ready,
    output logic [WIDTH-1:0] dout,
    output logic             feed,
    output logic             drain
);
    // Qualify the strobes so refused requests never reach the chain.
    always_comb begin
        in_ready  = ~head_full;
        out_ready = tail_full;
        dout      = tail_data;
        feed      = shift_in & ~head_full;
        drain     = shift_out & tail_full;
    end
endmodule

// File: rtl/ftf_fifo.sv
// ftf_fifo: top of the fall-through FIFO. Joins the handshake edge logic to
// the stage chain. Assumes one clock domain, a synchronous active-low reset
// and DEPTH >= 2.
module ftf_fifo
    import ftf_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    output logic             in_ready,
    input  logic [WIDTH-1:0] din,
    input  logic             shift_out,
    output logic             out_ready,
    output logic [WIDTH-1:0] dout
);
    logic [DEPTH-1:0] stage_full;
    logic [WIDTH-1:0] tail_word;
    logic             feed;
    logic             drain;

    ftf_port_ctrl #(.WIDTH(WIDTH)) u_ports (
        .shift_in (shift_in),
        .shift_out(shift_out),
        .head_full(stage_full[0]),
        .tail_full(stage_full[DEPTH-1]),
        .tail_data(tail_word),
        .in_ready (in_ready),
        .out_ready(out_ready),
        .dout     (dout),
        .feed     (feed),
        .drain    (drain)
    );

    ftf_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .feed     (feed),
        .feed_data(din),
        .drain    (drain),
        .marks    (stage_full),
        .tail_data(tail_word)
    );
endmodule

// File: rtl/ftf_fifo_chk.sv
// ftf_fifo_chk: property checker for ftf_fifo, attached with bind below.
// Assumes markers is the per-stage occupancy vector of the instance.
module ftf_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_in,
    input logic             in_ready,
    input logic             shift_out,
    input logic             out_ready,
    input logic [WIDTH-1:0] dout,
    input logic [DEPTH-1:0] markers
);
    int cnt;
    int acc_in;
    int acc_out;

    // Occupancy count and accepted transfers for this cycle.
    always_comb begin
        cnt     = $countones(markers);
        acc_in  = (shift_in && in_ready) ? 1 : 0;
        acc_out = (shift_out && out_ready) ? 1 : 0;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (markers == '0));

    // R7
    conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) + $past(acc_in) - $past(acc_out)));

    // R8
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == DEPTH) |-> !in_ready);

    // R5
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 0) |-> !out_ready);

    // R11
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !shift_out) |=> (out_ready && $stable(dout)));
endmodule

bind ftf_fifo ftf_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_in (shift_in),
    .in_ready (in_ready),
    .shift_out(shift_out),
    .out_ready(out_ready),
    .dout     (dout),
    .markers  (stage_full)
);

// File: tb/tb_ftf_fifo.sv
module tb_ftf_fifo;
    localparam int DEPTH = 16;
    localparam int WIDTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_in = 1'b0, shift_out = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic in_ready, out_ready;
    logic [WIDTH-1:0] dout;

    // cascade pair
    logic ca_shift_in = 1'b0, cb_shift_out = 1'b0;
    logic [WIDTH-1:0] ca_din = '0;
    logic ca_in_ready, a_out_ready, b_in_ready, cb_out_ready;
    logic [WIDTH-1:0] a_dout, cb_dout;

    int errors = 0, checks = 0, both_hits = 0;
    logic [WIDTH-1:0] mq[$];
    logic [WIDTH-1:0] cq[$];

    always #10ns clk = ~clk;

    ftf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .in_ready(in_ready),
        .din(din), .shift_out(shift_out), .out_ready(out_ready), .dout(dout));

    ftf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) cas_a (
        .clk(clk), .rst_n(rst_n), .shift_in(ca_shift_in), .in_ready(ca_in_ready),
        .din(ca_din), .shift_out(b_in_ready), .out_ready(a_out_ready), .dout(a_dout));

    ftf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) cas_b (
        .clk(clk), .rst_n(rst_n), .shift_in(a_out_ready), .in_ready(b_in_ready),
        .din(a_dout), .shift_out(cb_shift_out), .out_ready(cb_out_ready), .dout(cb_dout));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit roll(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    // One cycle on the single instance; the model follows accepted strobes.
    task automatic step(input bit si, input bit so, input logic [WIDTH-1:0] d);
        @(negedge clk);
        shift_in = si; shift_out = so; din = d;
        if (si && in_ready && so && out_ready) both_hits++;
        if (so && out_ready) begin
            if (mq.size() == 0) chk(1'b0, "R7 read from empty model", 1, 0);
            else begin
                logic [WIDTH-1:0] e;
                e = mq.pop_front();
                chk(dout == e, "R7 order", int'(dout), int'(e));
            end
        end
        if (si && in_ready) mq.push_back(d);
        @(posedge clk);
    endtask

    task automatic cstep(input bit si, input bit so, input logic [WIDTH-1:0] d);
        @(negedge clk);
        ca_shift_in = si; cb_shift_out = so; ca_din = d;
        if (so && cb_out_ready) begin
            if (cq.size() == 0) chk(1'b0, "R10 read from empty model", 1, 0);
            else begin
                logic [WIDTH-1:0] e;
                e = cq.pop_front();
                chk(cb_dout == e, "R10 order", int'(cb_dout), int'(e));
            end
        end
        if (si && ca_in_ready) cq.push_back(d);
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; shift_in = 0; shift_out = 0; ca_shift_in = 0; cb_shift_out = 0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        chk(out_ready == 1'b0, "R1 out_ready in reset", int'(out_ready), 0);
        mq.delete();
        cq.delete();
        rst_n = 1'b1;
    endtask

    task automatic drain_all();
        for (int i = 0; i < 4 * DEPTH && mq.size() > 0; i++) step(1'b0, 1'b1, '0);
        for (int i = 0; i < 2 * DEPTH; i++) step(1'b0, 1'b1, '0);
        chk(mq.size() == 0, "R7 all words delivered", mq.size(), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [WIDTH-1:0] held;
        int acc;
        void'($urandom(32'd1975));
        do_reset();

        // R4: fall-through latency, then R5 read
        @(negedge clk); shift_in = 1; din = 4'hA;
        @(posedge clk);
        @(negedge clk); shift_in = 0;
        for (int j = 0; j < DEPTH; j++) begin
            if (j > 0) @(negedge clk);
            chk(out_ready == (j >= DEPTH - 1), "R4 latency", int'(out_ready),
                int'(j >= DEPTH - 1));
            if (j < DEPTH - 1) @(posedge clk);
        end
        chk(dout == 4'hA, "R5 dout shows word", int'(dout), 10);
        shift_out = 1;
        @(posedge clk);
        @(negedge clk); shift_out = 0;
        chk(out_ready == 1'b0, "R5 word removed", int'(out_ready), 0);

        // R6: reads on empty ignored
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, '0);
        step(1'b1, 1'b0, 4'h5);
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, '0);
        chk(out_ready && dout == 4'h5, "R6 word after empty reads", int'(dout), 5);
        drain_all();
        chk(out_ready == 1'b0, "R6 nothing extra", int'(out_ready), 0);

        // R8 / R2: capacity
        do_reset();
        for (int i = 0; i < 6 * DEPTH; i++) step(1'b1, 1'b0, WIDTH'(i));
        chk(mq.size() == DEPTH, "R8 capacity", mq.size(), DEPTH);
        @(negedge clk);
        chk(in_ready == 1'b0, "R2 in_ready low when full", int'(in_ready), 0);

        // R3: writes while full ignored
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 4'hF);
        chk(mq.size() == DEPTH, "R3 full writes ignored", mq.size(), DEPTH);

        // R11: output holds while not read
        @(negedge clk);
        held = dout;
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b0, '0);
            @(negedge clk);
            chk(out_ready && dout == held, "R11 dout stable", int'(dout), int'(held));
        end
        drain_all();

        // R1: reset mid-run discards stored words
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, WIDTH'(i + 3));
        do_reset();
        for (int i = 0; i < 2 * DEPTH; i++) step(1'b0, 1'b1, '0);
        chk(out_ready == 1'b0, "R1 no stale word", int'(out_ready), 0);

        // R7 / R9: random phases
        for (int ph = 0; ph < 4; ph++) begin
            int pi, po;
            pi = (ph == 0) ? 80 : (ph == 1) ? 20 : (ph == 2) ? 50 : 90;
            po = (ph == 0) ? 20 : (ph == 1) ? 80 : (ph == 2) ? 50 : 90;
            for (int i = 0; i < 1000; i++)
                step(roll(pi), roll(po), WIDTH'($urandom));
        end
        drain_all();
        chk(both_hits > 0, "R9 same-cycle write and read seen", both_hits, 1);

        // R10: cascade depth and order
        for (int i = 0; i < 10 * DEPTH; i++) cstep(1'b1, 1'b0, WIDTH'($urandom));
        chk(cq.size() == 2 * DEPTH, "R10 cascade capacity", cq.size(), 2 * DEPTH);
        for (int i = 0; i < 2000; i++) cstep(roll(60), roll(60), WIDTH'($urandom));
        for (int i = 0; i < 10 * DEPTH; i++) cstep(1'b0, 1'b1, '0);
        acc = cq.size();
        chk(acc == 0, "R10 cascade drained", acc, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule